// File: doc/BRIEF.md
# Status-Encoded Bus Command Decoder

This block sits beside a processor that runs in its multi-master configuration and publishes its bus activity only as a three-bit status code. It rebuilds the individual bus command strobes from that code: memory read, memory write, I/O read, I/O write and interrupt acknowledge. It also produces an address latch strobe and the enable and direction controls for a data transceiver. The all-ones code is the passive (idle) code. A bus cycle begins when the sampled status leaves that code, and it ends when the code comes back.

A second decoder turns the processor's two segment-status bits into four active-low segment select lines. These lines can serve directly as chip selects for memory banks. Both inputs are registered on the rising clock. Every output is active low, and a synchronous reset drives every output to its inactive (high) level.

The cycle type is latched at the start of each cycle. A change of status code in the middle of a cycle therefore does not alter the strobe that is running. Status code 3'b011 (halt) opens a cycle that produces only the address latch pulse.

Top module: `bus_cmd_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, every output is high (inactive) after that edge.
- R2: `ale_n` is low for exactly one clock: the clock that follows the edge after which the registered status first holds a non-passive code (any code other than 3'b111) while the previous registered sample held 3'b111.
- R3: Status codes 3'b100 (code fetch) and 3'b101 (memory read) both drive `mem_rd_n` low during the command phase.
- R4: Status code 3'b110 drives `mem_wr_n` low and status code 3'b010 drives `io_wr_n` low during the command phase.
- R5: Status code 3'b001 drives `io_rd_n` low and status code 3'b000 drives `inta_n` low during the command phase.
- R6: Status code 3'b011 (halt) opens a cycle with an `ale_n` pulse but drives no command strobe and leaves `xcvr_en_n` high.
- R7: A command strobe goes low one clock after the `ale_n` pulse. It stays low until the rising edge at which the registered status is 3'b111, and it returns high at that edge. At most one strobe is low at any time.
- R8: A change from one non-passive code to another inside a cycle leaves the strobe chosen at cycle start unchanged.
- R9: `xcvr_en_n` is low exactly while a command strobe is low. `xcvr_tx_n` is low (transmit) during the address and command phases of a cycle started with 3'b010 or 3'b110, and high otherwise.
- R10: `seg_sel_n` goes low on one bit, one clock after sampling, with all other bits high. Segment input 2'b00 (extra) selects bit 0, 2'b01 (stack) selects bit 1, 2'b10 (code) selects bit 2 and 2'b11 (data) selects bit 3.
- R11: If the status returns to 3'b111 by the sample that would start the command phase, the cycle ends after the `ale_n` pulse and no command strobe is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| status_in | input | 3 | Encoded bus status from the processor |
| seg_in | input | 2 | Segment-status bits from the processor |
| ale_n | output | 1 | Address latch strobe, active low |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| io_rd_n | output | 1 | I/O read command, active low |
| io_wr_n | output | 1 | I/O write command, active low |
| inta_n | output | 1 | Interrupt acknowledge command, active low |
| xcvr_en_n | output | 1 | Data transceiver enable, active low |
| xcvr_tx_n | output | 1 | Transceiver direction, low means transmit (write) |
| seg_sel_n | output | 4 | Decoded segment selects, active low |

## Verification
The assertions assume that `rst` is high at the first clock edge. They also assume that `status_in` and `seg_in` are stable around each rising edge, so that every registered sample is a clean code. The bench changes both inputs only on the falling edge and holds reset for several clocks at the start. Its random bus cycles always separate cycles with at least one passive sample. They also include one-clock cycles, halt cycles and code changes in the middle of a cycle, so that every path the assertions cover is exercised.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

  typedef enum logic [2:0] {
    ST_INTA    = 3'b000,
    ST_IORD    = 3'b001,
    ST_IOWR    = 3'b010,
    ST_HALT    = 3'b011,
    ST_FETCH   = 3'b100,
    ST_MRD     = 3'b101,
    ST_MWR     = 3'b110,
    ST_PASSIVE = 3'b111
  } bus_status_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_CMD  = 2'd2
  } phase_e;

  // active-high command set, inverted at the port
  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic io_rd;
    logic io_wr;
    logic inta;
  } cmd_t;

  function automatic cmd_t cmd_of(input logic [2:0] code);
    cmd_t c;
    c = '0;
    case (code)
      ST_FETCH, ST_MRD: c.mem_rd = 1'b1;
      ST_MWR:           c.mem_wr = 1'b1;
      ST_IORD:          c.io_rd  = 1'b1;
      ST_IOWR:          c.io_wr  = 1'b1;
      ST_INTA:          c.inta   = 1'b1;
      default:          c = '0;
    endcase
    return c;
  endfunction

  function automatic logic is_write(input logic [2:0] code);
    return (code == ST_MWR) || (code == ST_IOWR);
  endfunction

endpackage

// File: rtl/bcd_status_sampler.sv
module bcd_status_sampler
  import bcd_pkg::*;
#(
  parameter int ST_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] status_in,
  output logic [ST_W-1:0] st_q,
  output logic [ST_W-1:0] prev_q
);
  localparam logic [ST_W-1:0] IDLE_CODE = {ST_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= IDLE_CODE;
      prev_q <= IDLE_CODE;
    end else begin
      st_q   <= status_in;
      prev_q <= st_q;
    end
  end
endmodule

// File: rtl/bcd_cycle_tracker.sv
module bcd_cycle_tracker
  import bcd_pkg::*;
#(
  parameter int ST_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] st_q,
  input  logic [ST_W-1:0] prev_q,
  output phase_e          phase,
  output logic [ST_W-1:0] cyc_code,
  output logic            start_evt,
  output logic            end_evt
);
  localparam logic [ST_W-1:0] IDLE_CODE = {ST_W{1'b1}};

  assign start_evt = (prev_q == IDLE_CODE) && (st_q != IDLE_CODE);
  assign end_evt   = (phase != PH_IDLE) && (st_q == IDLE_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cyc_code <= IDLE_CODE;
    end else if (start_evt) begin
      phase    <= PH_ADDR;
      cyc_code <= st_q;
    end else if (end_evt) begin
      phase    <= PH_IDLE;
    end else if (phase == PH_ADDR) begin
      phase    <= PH_CMD;
    end
  end
endmodule

// File: rtl/bcd_cmd_decoder.sv
module bcd_cmd_decoder
  import bcd_pkg::*;
(
  input  phase_e     phase,
  input  logic [2:0] cyc_code,
  output logic       ale_n,
  output cmd_t       cmd,
  output logic       xcvr_en_n,
  output logic       xcvr_tx_n
);
  logic in_cmd;
  logic in_cyc;

  assign in_cmd    = (phase == PH_CMD);
  assign in_cyc    = (phase != PH_IDLE);
  assign ale_n     = !(phase == PH_ADDR);
  assign cmd       = in_cmd ? cmd_of(cyc_code) : '0;
  assign xcvr_en_n = !(|cmd);
  assign xcvr_tx_n = !(in_cyc && is_write(cyc_code));
endmodule

// File: rtl/bcd_seg_decoder.sv
module bcd_seg_decoder #(
  parameter int SEG_W = 2,
  localparam int SEG_N = 1 << SEG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEG_W-1:0] seg_in,
  output logic [SEG_N-1:0] seg_sel_n
);
  for (genvar i = 0; i < SEG_N; i++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst) seg_sel_n[i] <= 1'b1;
      else     seg_sel_n[i] <= !(seg_in == SEG_W'(i));
    end
  end
endmodule

// File: rtl/bus_cmd_decoder.sv
module bus_cmd_decoder
  import bcd_pkg::*;
#(
  parameter int SEG_W = 2,
  localparam int SEG_N = 1 << SEG_W,
  localparam int ST_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ST_W-1:0]  status_in,
  input  logic [SEG_W-1:0] seg_in,
  output logic             ale_n,
  output logic             mem_rd_n,
  output logic             mem_wr_n,
  output logic             io_rd_n,
  output logic             io_wr_n,
  output logic             inta_n,
  output logic             xcvr_en_n,
  output logic             xcvr_tx_n,
  output logic [SEG_N-1:0] seg_sel_n
);
  logic [ST_W-1:0] st_q;
  logic [ST_W-1:0] prev_q;
  logic [ST_W-1:0] cyc_code;
  phase_e          phase;
  logic            start_evt;
  logic            end_evt;
  cmd_t            cmd;

  bcd_status_sampler #(.ST_W(ST_W)) u_samp (
    .clk(clk), .rst(rst), .status_in(status_in), .st_q(st_q), .prev_q(prev_q)
  );

  bcd_cycle_tracker #(.ST_W(ST_W)) u_trk (
    .clk(clk), .rst(rst), .st_q(st_q), .prev_q(prev_q), .phase(phase),
    .cyc_code(cyc_code), .start_evt(start_evt), .end_evt(end_evt)
  );

  bcd_cmd_decoder u_dec (
    .phase(phase), .cyc_code(cyc_code), .ale_n(ale_n), .cmd(cmd),
    .xcvr_en_n(xcvr_en_n), .xcvr_tx_n(xcvr_tx_n)
  );

  bcd_seg_decoder #(.SEG_W(SEG_W)) u_seg (
    .clk(clk), .rst(rst), .seg_in(seg_in), .seg_sel_n(seg_sel_n)
  );

  assign mem_rd_n = !cmd.mem_rd;
  assign mem_wr_n = !cmd.mem_wr;
  assign io_rd_n  = !cmd.io_rd;
  assign io_wr_n  = !cmd.io_wr;
  assign inta_n   = !cmd.inta;
endmodule

// File: rtl/bus_cmd_decoder_chk.sv
module bus_cmd_decoder_chk #(
  parameter int SEG_N = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             ale_n,
  input logic             mem_rd_n,
  input logic             mem_wr_n,
  input logic             io_rd_n,
  input logic             io_wr_n,
  input logic             inta_n,
  input logic             xcvr_en_n,
  input logic             xcvr_tx_n,
  input logic [SEG_N-1:0] seg_sel_n,
  input logic             start_evt,
  input logic             end_evt
);
  logic [4:0] strobes_n;
  logic       cmd_idle;
  assign strobes_n = {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, inta_n};
  assign cmd_idle  = &strobes_n;

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (ale_n && cmd_idle && xcvr_en_n && xcvr_tx_n && (&seg_sel_n)));

  p_ale_single_r2: assert property (@(posedge clk) disable iff (rst)
    !ale_n |=> ale_n);

  p_start_ale_r2: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> !ale_n);

  p_one_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~strobes_n));

  p_strobe_after_ale_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_idle) |-> $past(!ale_n));

  p_end_release_r7: assert property (@(posedge clk) disable iff (rst)
    end_evt |=> cmd_idle);

  p_xcvr_follows_r9: assert property (@(posedge clk) disable iff (rst)
    !xcvr_en_n |-> !cmd_idle);

  p_seg_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ($countones(~seg_sel_n) == 1));
endmodule

bind bus_cmd_decoder bus_cmd_decoder_chk #(.SEG_N(SEG_N)) u_chk (
  .clk(clk), .rst(rst), .ale_n(ale_n), .mem_rd_n(mem_rd_n),
  .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
  .inta_n(inta_n), .xcvr_en_n(xcvr_en_n), .xcvr_tx_n(xcvr_tx_n),
  .seg_sel_n(seg_sel_n), .start_evt(start_evt), .end_evt(end_evt)
);

// File: tb/tb_bus_cmd_decoder.sv
module tb_bus_cmd_decoder;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] status_in = 3'b111;
  logic [1:0] seg_in = 2'b00;
  logic       ale_n, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, inta_n;
  logic       xcvr_en_n, xcvr_tx_n;
  logic [3:0] seg_sel_n;

  bus_cmd_decoder dut (
    .clk(clk), .rst(rst), .status_in(status_in), .seg_in(seg_in),
    .ale_n(ale_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .inta_n(inta_n),
    .xcvr_en_n(xcvr_en_n), .xcvr_tx_n(xcvr_tx_n), .seg_sel_n(seg_sel_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string tag_override = "";
  bit done = 0;

  // reference model: age 0 idle, 1 address clock, 2 command
  logic [2:0] m_now = 3'b111, m_old = 3'b111, m_code = 3'b111;
  int         m_age = 0;
  logic [3:0] m_seg = 4'hF;

  function automatic logic [4:0] exp_cmd(input int age, input logic [2:0] code);
    logic [4:0] v;
    v = 5'b11111; // {mem_rd, mem_wr, io_rd, io_wr, inta}
    if (age == 2) begin
      if (code == 3'b100 || code == 3'b101) v[4] = 1'b0;
      else if (code == 3'b110) v[3] = 1'b0;
      else if (code == 3'b001) v[2] = 1'b0;
      else if (code == 3'b010) v[1] = 1'b0;
      else if (code == 3'b000) v[0] = 1'b0;
    end
    return v;
  endfunction

  function automatic string code_tag(input logic [2:0] code);
    case (code)
      3'b100, 3'b101: return "R3";
      3'b110, 3'b010: return "R4";
      3'b001, 3'b000: return "R5";
      3'b011:         return "R6";
      default:        return "R7";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_now = 3'b111; m_old = 3'b111; m_age = 0; m_seg = 4'hF;
    end else begin
      if (m_old == 3'b111 && m_now != 3'b111) begin
        m_age = 1; m_code = m_now;
      end else if (m_age != 0 && m_now == 3'b111) m_age = 0;
      else if (m_age == 1) m_age = 2;
      m_old = m_now;
      m_now = status_in;
      m_seg = 4'hF;
      m_seg[seg_in] = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    if (!rst && !done) begin
      string t;
      logic [4:0] ec;
      logic en_exp, tx_exp;
      ec = exp_cmd(m_age, m_code);
      en_exp = (m_age == 2) ? &ec : 1'b1;
      tx_exp = !(m_age != 0 && (m_code == 3'b110 || m_code == 3'b010));
      t = (tag_override != "") ? tag_override :
          ((m_age != 0) ? code_tag(m_code) : "R7");
      chk("R2 ale", {7'd0, ale_n}, {7'd0, !(m_age == 1)});
      chk(t, {3'd0, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, inta_n}, {3'd0, ec});
      chk("R9 xcvr", {6'd0, xcvr_en_n, xcvr_tx_n}, {6'd0, en_exp, tx_exp});
      chk("R10 seg", {4'd0, seg_sel_n}, {4'd0, m_seg});
    end
  end

  task automatic drive(input logic [2:0] st, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      status_in = st;
      seg_in = 2'($urandom_range(0, 3));
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    // R1: outputs inactive under reset
    chk("R1 reset", {ale_n, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, inta_n, xcvr_en_n, xcvr_tx_n},
        8'hFF);
    chk("R1 reset seg", {4'd0, seg_sel_n}, 8'h0F);
    @(negedge clk); rst = 1'b0;
    drive(3'b111, 2);
    // directed: each code one cycle of three samples
    for (int c = 0; c < 7; c++) begin
      drive(3'(c), 3);
      drive(3'b111, 2);
    end
    // R7: long command held until passive
    tag_override = "R7";
    drive(3'b101, 6); drive(3'b111, 2);
    // R8: mid-cycle change of code
    tag_override = "R8";
    drive(3'b101, 2); drive(3'b110, 3); drive(3'b001, 1); drive(3'b111, 2);
    // R11: single-sample cycle, no strobe
    tag_override = "R11";
    drive(3'b110, 1); drive(3'b111, 3);
    drive(3'b000, 1); drive(3'b111, 1);
    tag_override = "";
    // R10 explicit segment sweep
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); seg_in = 2'(s);
      @(negedge clk);
      chk("R10 sweep", {4'd0, seg_sel_n}, {4'd0, ~(4'b0001 << s)});
    end
    // random bus traffic
    for (int k = 0; k < 400; k++) begin
      drive(3'($urandom_range(0, 6)), $urandom_range(1, 5));
      if ($urandom_range(0, 3) == 0) drive(3'($urandom_range(0, 6)), $urandom_range(1, 2));
      drive(3'b111, $urandom_range(1, 3));
    end
    // reset in mid-cycle
    drive(3'b110, 3);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 mid reset", {ale_n, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, inta_n, xcvr_en_n, xcvr_tx_n},
        8'hFF);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule